// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is a byte-wide configuration window on a simple I/O bus. It uses two adjacent byte addresses. A write to the lower address loads an 8-bit pointer. Reads and writes at the upper address then act on the one of 256 configuration bytes that the pointer selects. A read at either address returns the byte under the pointer. A fixed per-pointer policy decides what happens to a data write: it is stored, it is dropped, or it is stored only when it carries one specific value. The keyed bytes hold base addresses that must not move, so only their existing value is accepted.

The whole window is gated by an enable input, which the host side drives from bit 1 of one of its own control bytes. The enable is low after reset. While the enable is low the block decodes no access. Reset loads a small set of non-zero defaults, and every other byte and the pointer start at zero. Only single-byte accesses exist.

Top module: `cfg_index_port`

## Requirements
- R1: A write with `portEnable` high at address `BASE_ADDR` (default 0x03F0) loads `ioWdata` into the pointer on that clock edge.
- R2: With `portEnable` high and `ioRead` high at `BASE_ADDR` or `BASE_ADDR+1`, `ioRdata` shows the byte under the pointer in the same cycle, whatever the write protection. When a read and a write fall in the same cycle, the read returns the value from before the edge.
- R3: A data write (address `BASE_ADDR+1`) is dropped when the pointer is 0x00–0xDF, 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R4: At pointer 0xE7 a data write is stored only if the value is 0xFE. At pointer 0xE8 it is stored only if the value is 0xBE. Any other value leaves the byte unchanged.
- R5: At pointers 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 and 0xFC a data write is stored unconditionally, and a read in the next cycle returns it.
- R6: After reset, 0xE0=0x3C, 0xE2=0x03, 0xE3=0xFC, 0xE6=0xDE, 0xE7=0xFE and 0xE8=0xBE. Every other byte is 0x00 and the pointer is 0x00.
- R7: While `portEnable` is low, reads return 0xFF, and writes change neither the pointer nor any byte.
- R8: An access at any address other than the two port addresses returns 0xFF and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEnable | input | 1 | Window enable, from host control bit 1 |
| ioAddr | input | 16 | I/O byte address |
| ioRead | input | 1 | Read strobe, valid for one cycle |
| ioWrite | input | 1 | Write strobe, takes effect at the clock edge |
| ioWdata | input | 8 | Write byte |
| ioRdata | output | 8 | Read byte, 0xFF when no read is decoded |

## Verification
A read and a write can land in the same cycle: a data read together with a data write to the same byte, or a read together with a pointer load. The bench raises both strobes in one cycle. It checks that the combinational read shows the pre-edge byte or the pre-edge pointer target. A read in the following cycle must then show the stored byte or the new pointer target. Random stimulus also toggles the enable between accesses, so that gating and the protection map are exercised together.

// File: rtl/cfgport_pkg.sv
package cfgport_pkg;

  typedef struct packed {
    logic idxLoad;    // load pointer from write byte
    logic dataStore;  // store write byte at pointer
    logic rdDrive;    // drive selected byte on read bus
  } cfgStrobes_t;

  typedef enum logic [1:0] {
    POL_LOCK  = 2'd0,
    POL_OPEN  = 2'd1,
    POL_KEYED = 2'd2
  } wrPolicy_e;

  function automatic wrPolicy_e policyOf(input logic [7:0] idx);
    if (idx inside {[8'h00:8'hDF], 8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5,
                    8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]})
      return POL_LOCK;
    else if (idx inside {8'hE7, 8'hE8})
      return POL_KEYED;
    else
      return POL_OPEN;
  endfunction

  function automatic logic [7:0] keyOf(input logic [7:0] idx);
    return (idx == 8'hE7) ? 8'hFE : 8'hBE;
  endfunction

  function automatic logic [7:0] resetByte(input logic [7:0] idx);
    case (idx)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return 8'hFE;
      8'hE8:   return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/cfgport_ctrl.sv
module cfgport_ctrl
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              portEnable,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRead,
  input  logic              ioWrite,
  input  logic [DATA_W-1:0] ioWdata,
  input  logic [DATA_W-1:0] curIndex,
  output cfgStrobes_t       strb
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  logic hitIdx, hitData, writeOk;
  wrPolicy_e pol;

  always_comb begin
    hitIdx  = portEnable && (ioAddr == BASE_ADDR);
    hitData = portEnable && (ioAddr == DATA_ADDR);
    pol     = policyOf(curIndex);
    unique case (pol)
      POL_OPEN:  writeOk = 1'b1;
      POL_KEYED: writeOk = (ioWdata == keyOf(curIndex));
      default:   writeOk = 1'b0;
    endcase
    strb.idxLoad   = ioWrite && hitIdx;
    strb.dataStore = ioWrite && hitData && writeOk;
    strb.rdDrive   = ioRead && (hitIdx || hitData);
  end
endmodule

// File: rtl/cfgport_dpath.sv
module cfgport_dpath
  import cfgport_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  cfgStrobes_t       strb,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] curIndex,
  output logic [DATA_W-1:0] selByte
);
  localparam int DEPTH = 1 << DATA_W;

  logic [DATA_W-1:0] cfgMem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curIndex <= '0;
    end else if (strb.idxLoad) begin
      curIndex <= ioWdata;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : gByte
      always_ff @(posedge clk) begin
        if (!rstN) begin
          cfgMem[g] <= resetByte(8'(g));
        end else if (strb.dataStore && (curIndex == DATA_W'(g))) begin
          cfgMem[g] <= ioWdata;
        end
      end
    end
  endgenerate

  assign selByte = cfgMem[curIndex];
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port
  import cfgport_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              portEnable,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic              ioRead,
  input  logic              ioWrite,
  input  logic [DATA_W-1:0] ioWdata,
  output logic [DATA_W-1:0] ioRdata
);
  cfgStrobes_t       strb;
  logic [DATA_W-1:0] curIndex;
  logic [DATA_W-1:0] selByte;

  cfgport_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_ctrl (
    .portEnable(portEnable), .ioAddr(ioAddr), .ioRead(ioRead), .ioWrite(ioWrite),
    .ioWdata(ioWdata), .curIndex(curIndex), .strb(strb)
  );

  cfgport_dpath #(.DATA_W(DATA_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strb(strb), .ioWdata(ioWdata),
    .curIndex(curIndex), .selByte(selByte)
  );

  assign ioRdata = strb.rdDrive ? selByte : '1;
endmodule

// File: rtl/cfgport_checker.sv
module cfgport_checker #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'h03F0
) (
  input logic              clk,
  input logic              rstN,
  input logic              portEnable,
  input logic [ADDR_W-1:0] ioAddr,
  input logic              ioWrite,
  input logic [DATA_W-1:0] ioWdata,
  input logic [DATA_W-1:0] ioRdata,
  input logic [DATA_W-1:0] curIndex,
  input logic [DATA_W-1:0] selByte
);
  localparam logic [ADDR_W-1:0] DATA_ADDR = BASE_ADDR + ADDR_W'(1);

  AST_GATED_READ_FF: assert property (@(posedge clk) disable iff (!rstN)
    !portEnable |-> ioRdata == '1); // R7

  AST_INDEX_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ioWrite && ioAddr == BASE_ADDR) |=> curIndex == $past(ioWdata)); // R1

  AST_GATED_INDEX_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !portEnable |=> $stable(curIndex)); // R7

  AST_LOCKED_LOW_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ioWrite && ioAddr == DATA_ADDR && curIndex < 8'hE0) |=> $stable(selByte)); // R3

  AST_KEY_REJECT: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ioWrite && ioAddr == DATA_ADDR &&
     ((curIndex == 8'hE7 && ioWdata != 8'hFE) || (curIndex == 8'hE8 && ioWdata != 8'hBE)))
    |=> $stable(selByte)); // R4

  AST_OPEN_STORE: assert property (@(posedge clk) disable iff (!rstN)
    (portEnable && ioWrite && ioAddr == DATA_ADDR && curIndex == 8'hE0)
    |=> selByte == $past(ioWdata)); // R5
endmodule

bind cfg_index_port cfgport_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .portEnable(portEnable), .ioAddr(ioAddr), .ioWrite(ioWrite),
  .ioWdata(ioWdata), .ioRdata(ioRdata), .curIndex(curIndex), .selByte(selByte)
);

// File: tb/cfg_index_port_bench.sv
module cfg_index_port_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [15:0] BASE = 16'h03F0;

  logic clk = 1'b0, rstN = 1'b0, portEnable = 1'b0;
  logic [15:0] ioAddr = '0;
  logic ioRead = 1'b0, ioWrite = 1'b0;
  logic [7:0] ioWdata = '0;
  logic [7:0] ioRdata;

  int nChecks = 0, nFail = 0;
  logic [7:0] model [256];
  logic [7:0] mIdx;

  always #(CLK_PERIOD/2) clk = ~clk;

  cfg_index_port u_cfg_index_port (
    .clk(clk), .rstN(rstN), .portEnable(portEnable), .ioAddr(ioAddr),
    .ioRead(ioRead), .ioWrite(ioWrite), .ioWdata(ioWdata), .ioRdata(ioRdata)
  );

  // 0 locked, 1 open, 2 keyed
  function automatic int polOf(input logic [7:0] i);
    if (i <= 8'hDF || i == 8'hE4 || i == 8'hE5 || (i >= 8'hE9 && i <= 8'hED) ||
        i == 8'hF3 || i == 8'hF5 || i == 8'hF7 || (i >= 8'hF9 && i <= 8'hFB) ||
        i >= 8'hFD) return 0;
    if (i == 8'hE7 || i == 8'hE8) return 2;
    return 1;
  endfunction

  function automatic logic [7:0] defOf(input logic [7:0] i);
    case (i)
      8'hE0: return 8'h3C; 8'hE2: return 8'h03; 8'hE3: return 8'hFC;
      8'hE6: return 8'hDE; 8'hE7: return 8'hFE; 8'hE8: return 8'hBE;
      default: return 8'h00;
    endcase
  endfunction

  function automatic bit storesOk(input logic [7:0] i, input logic [7:0] v);
    int p = polOf(i);
    if (p == 1) return 1'b1;
    if (p == 2) return (i == 8'hE7) ? (v == 8'hFE) : (v == 8'hBE);
    return 1'b0;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic modelWrite(input logic [15:0] a, input logic [7:0] d);
    if (!portEnable) return;
    if (a == BASE) mIdx = d;
    else if (a == BASE + 16'd1 && storesOk(mIdx, d)) model[mIdx] = d;
  endtask

  task automatic ioWr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    ioAddr = a; ioWdata = d; ioWrite = 1'b1;
    @(negedge clk);
    ioWrite = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic ioRd(input logic [15:0] a, input string req);
    logic [7:0] exp;
    @(negedge clk);
    ioAddr = a; ioRead = 1'b1;
    #1;
    exp = (portEnable && (a == BASE || a == BASE + 16'd1)) ? model[mIdx] : 8'hFF;
    check(req, ioRdata, exp);
    ioRead = 1'b0;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finishRun();
  end

  initial begin
    void'($urandom(32'h1D5E));
    for (int i = 0; i < 256; i++) model[i] = defOf(8'(i));
    mIdx = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R7: disabled after reset, reads 0xFF, writes ignored
    ioRd(BASE + 16'd1, "R7 disabled read");
    ioWr(BASE, 8'hE0);
    ioWr(BASE + 16'd1, 8'h55);
    portEnable = 1'b1;
    // R6: pointer still 0 and byte 0 is zero
    ioRd(BASE + 16'd1, "R6 R7 reset pointer/byte0");
    // R6: defaults of the upper window
    for (int i = 8'hE0; i <= 8'hFF; i++) begin
      ioWr(BASE, 8'(i));
      ioRd(BASE + 16'd1, "R6 reset default");
    end
    // R3: locked indices keep values
    ioWr(BASE, 8'h10); ioWr(BASE + 16'd1, 8'hA5); ioRd(BASE, "R3 locked low");
    ioWr(BASE, 8'hE4); ioWr(BASE + 16'd1, 8'h77); ioRd(BASE + 16'd1, "R3 locked E4");
    ioWr(BASE, 8'hFF); ioWr(BASE + 16'd1, 8'h12); ioRd(BASE + 16'd1, "R3 locked FF");
    // R4: keyed indices
    ioWr(BASE, 8'hE7); ioWr(BASE + 16'd1, 8'hFC); ioRd(BASE + 16'd1, "R4 E7 reject");
    ioWr(BASE + 16'd1, 8'hFE); ioRd(BASE + 16'd1, "R4 E7 accept");
    ioWr(BASE, 8'hE8); ioWr(BASE + 16'd1, 8'h00); ioRd(BASE + 16'd1, "R4 E8 reject");
    // R5: open index store, read next cycle
    ioWr(BASE, 8'hF4); ioWr(BASE + 16'd1, 8'h9A); ioRd(BASE + 16'd1, "R5 open F4");
    ioWr(BASE, 8'hE1); ioWr(BASE + 16'd1, 8'h42); ioRd(BASE, "R2 R5 read at index addr");
    // R8: other addresses
    ioRd(BASE + 16'd2, "R8 foreign read");
    ioWr(BASE + 16'd2, 8'h00); ioWr(16'h03EF, 8'hE0); ioRd(BASE + 16'd1, "R8 foreign write");

    // R2: read and data write in the same cycle
    @(negedge clk);
    ioAddr = BASE + 16'd1; ioWdata = 8'h5C; ioWrite = 1'b1; ioRead = 1'b1;
    #1; check("R2 same-cycle read old", ioRdata, model[mIdx]);
    @(negedge clk);
    ioWrite = 1'b0; ioRead = 1'b0;
    modelWrite(BASE + 16'd1, 8'h5C);
    ioRd(BASE + 16'd1, "R2 R5 next-cycle new");
    // R2: read together with pointer load
    @(negedge clk);
    ioAddr = BASE; ioWdata = 8'hE3; ioWrite = 1'b1; ioRead = 1'b1;
    #1; check("R2 R1 read with pointer load", ioRdata, model[mIdx]);
    @(negedge clk);
    ioWrite = 1'b0; ioRead = 1'b0;
    modelWrite(BASE, 8'hE3);
    ioRd(BASE + 16'd1, "R1 new pointer target");

    // Random mix
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom_range(0, 9);
      logic [7:0] v = 8'($urandom);
      if (op == 0) portEnable = ($urandom_range(0, 3) != 0);
      else if (op <= 3) ioWr(BASE, ($urandom_range(0, 3) == 0) ? v : (8'hE0 | (v & 8'h1F)));
      else if (op <= 6) begin
        if ($urandom_range(0, 3) == 0) v = (mIdx == 8'hE7) ? 8'hFE : 8'hBE;
        ioWr(BASE + 16'd1, v);
      end else if (op == 7) ioWr(16'($urandom), v);
      else ioRd(($urandom_range(0, 7) == 0) ? 16'($urandom) : (BASE + 16'($urandom_range(0, 1))),
                "R2 R3 R4 R5 R7 R8 random");
    end
    finishRun();
  end
endmodule